// File: doc/BRIEF.md
# Clock ratio and speed mode detector

This block watches the three clocks of a serial audio input (master clock, bit clock and word clock) and works out how the stream is clocked. It counts master-clock rising edges over each word-clock period to get the master-to-sample ratio. It also counts cycles of its own free-running reference clock over the same period to measure the absolute sample rate, which places the stream in single, double or quad speed. A result is published only once it has held steady for several periods, and only if the measured ratio is one that the detected speed allows.

The three audio clocks are asynchronous inputs. They are synchronised into the reference domain, and their rising edges are detected there. For that reason the reference clock must run faster than twice the highest master clock. Any clock that stops for longer than a timeout withdraws the result. A later change of ratio while locked produces a one-cycle change event, after which the block locks again to the new ratio.

Top module: `rate_mode_detect`

## Requirements
- R1: After reset, `rateValid` is 0, `ratioCode` is 7 (none), `speedMode` is 0 (none) and `ratioChange` is 0. Whenever `rateValid` is 0, `ratioCode` reads 7 and `speedMode` reads 0.
- R2: A word-clock period runs from one rising word-clock edge to the next. The ratio is the number of master-clock rising edges in that period, matched within ±2 to one of the codes 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1024. A count that matches no code never locks.
- R3: The sample rate is `REF_HZ` divided by the period length in reference cycles. The speed mode codes are 1 for 8–54 kHz, 2 for 84–108 kHz and 3 for 170–216 kHz. A rate outside all three windows never locks.
- R4: Each speed mode allows only some ratios. Single speed allows codes 2..6, double speed allows codes 0..4 and quad speed allows codes 0..2. A ratio that the mode does not allow never locks.
- R5: The period that ends at the first word-clock edge after reset is discarded. `rateValid` rises after 4 consecutive good periods whose counts each lie within ±2 of the previous one. This happens on the 4th reference clock edge after the 5th rising word-clock edge, and not earlier.
- R6: A good period whose count differs from the previous period by more than 2 restarts the run. A stream that alternates in this way never locks.
- R7: While locked, a single period that differs from the locked ratio or mode is ignored. Two consecutive differing periods produce a one-cycle `ratioChange` pulse, and `rateValid` clears in the same cycle.
- R8: After a change event, the block locks to the new ratio once 4 consistent periods have been seen, counting the second differing period.
- R9: A clock counts as absent when it has had no rising edge for `REF_HZ/4000` reference cycles, or has never had one since reset. While any of the three clocks is absent, `rateValid` is 0, no `ratioChange` pulse is given and no lock is made.
- R10: While `rateValid` stays high, `ratioCode` and `speedMode` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timebase clock at REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclkIn | input | 1 | Master clock, asynchronous |
| bclkIn | input | 1 | Bit clock, asynchronous |
| wclkIn | input | 1 | Word clock, asynchronous |
| ratioCode | output | 3 | Locked ratio code, 7 when not locked |
| speedMode | output | 2 | Locked speed mode, 0 when not locked |
| rateValid | output | 1 | Ratio and mode are locked |
| ratioChange | output | 1 | One-cycle pulse when the locked ratio is dropped |

## Verification
Each word-clock edge takes three reference edges to pass the synchroniser and the period registers. The lock and change decisions take one more edge. So `rateValid` and `ratioChange` move on the fourth reference edge after the deciding word-clock edge. A clock loss shows about `REF_HZ/4000` plus three cycles after that clock's last rising edge. The bench drives whole frames and samples the outputs on falling edges at frame boundaries. Each sample point lies well past the cycle in which a result is due, and before the next word-clock edge could move it. The "not yet locked" check sits just before the fifth word-clock edge. The loss checks bracket the timeout from both sides.

// File: rtl/rate_mode_pkg.sv
package rate_mode_pkg;

  typedef enum logic [2:0] {
    RC_128  = 3'd0,
    RC_192  = 3'd1,
    RC_256  = 3'd2,
    RC_384  = 3'd3,
    RC_512  = 3'd4,
    RC_768  = 3'd5,
    RC_1024 = 3'd6,
    RC_NONE = 3'd7
  } ratio_code_e;

  typedef enum logic [1:0] {
    SM_NONE   = 2'd0,
    SM_SINGLE = 2'd1,
    SM_DOUBLE = 2'd2,
    SM_QUAD   = 2'd3
  } speed_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic lockLoad;
    logic lockClear;
  } lock_cmd_t;

  // datapath -> control status
  typedef struct packed {
    logic strobe;
    logic good;
    logic nearPrev;
    logic sameAsLocked;
    logic allAlive;
  } meas_stat_t;

  localparam int NUM_PINS   = 3;
  localparam int MCLK_IX    = 0;
  localparam int BCLK_IX    = 1;
  localparam int WCLK_IX    = 2;
  localparam int NUM_RATIOS = 7;

  // sample-rate windows in Hz
  localparam int SINGLE_LO_HZ = 8000;
  localparam int SINGLE_HI_HZ = 54000;
  localparam int DOUBLE_LO_HZ = 84000;
  localparam int DOUBLE_HI_HZ = 108000;
  localparam int QUAD_LO_HZ   = 170000;
  localparam int QUAD_HI_HZ   = 216000;

  // even codes are 128 * 2^n, odd codes are 192 * 2^n
  function automatic int ratioNominal(int k);
    return (((k % 2) == 0) ? 128 : 192) << (k / 2);
  endfunction

  function automatic logic modeAllows(speed_mode_e m, ratio_code_e c);
    int ci;
    ci = int'(c);
    case (m)
      SM_SINGLE: return (ci >= 2) && (ci <= 6);
      SM_DOUBLE: return ci <= 4;
      SM_QUAD:   return ci <= 2;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rate_meas_path.sv
module rate_meas_path
  import rate_mode_pkg::*;
#(
  parameter int REF_HZ      = 200_000_000,
  parameter int TIMEOUT_DIV = 4000,
  parameter int TOL         = 2,
  parameter int MAX_RATIO   = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinsIn,
  input  lock_cmd_t           lockCmd,
  output meas_stat_t          measStat,
  output ratio_code_e         lockedCode,
  output speed_mode_e         lockedMode
);

  localparam int TIMEOUT_CYC = REF_HZ / TIMEOUT_DIV;
  localparam int REF_W       = $clog2(TIMEOUT_CYC + 2);
  localparam int MC_W        = $clog2(MAX_RATIO * 2);

  localparam logic [REF_W-1:0] TIMEOUT_V  = REF_W'(TIMEOUT_CYC);
  localparam logic [REF_W-1:0] SINGLE_MIN = REF_W'(REF_HZ / SINGLE_HI_HZ);
  localparam logic [REF_W-1:0] SINGLE_MAX = REF_W'(REF_HZ / SINGLE_LO_HZ);
  localparam logic [REF_W-1:0] DOUBLE_MIN = REF_W'(REF_HZ / DOUBLE_HI_HZ);
  localparam logic [REF_W-1:0] DOUBLE_MAX = REF_W'(REF_HZ / DOUBLE_LO_HZ);
  localparam logic [REF_W-1:0] QUAD_MIN   = REF_W'(REF_HZ / QUAD_HI_HZ);
  localparam logic [REF_W-1:0] QUAD_MAX   = REF_W'(REF_HZ / QUAD_LO_HZ);
  localparam logic [MC_W-1:0]  TOL_V      = MC_W'(TOL);

  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] pinAlive;

  // per-pin synchroniser, edge detect and activity timer
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [2:0]       syncSh;
    logic [REF_W-1:0] idleCnt;

    assign pinRise[g]  = syncSh[1] & ~syncSh[2];
    assign pinAlive[g] = idleCnt < TIMEOUT_V;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncSh  <= '0;
        idleCnt <= TIMEOUT_V;
      end else begin
        syncSh <= {syncSh[1:0], pinsIn[g]};
        if (pinRise[g])
          idleCnt <= '0;
        else if (idleCnt != TIMEOUT_V)
          idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  logic            mRise, wRise;
  logic [MC_W-1:0] mclkRun, mclkNext, periodMclk, prevMclk, gap;
  logic [REF_W-1:0] refRun, refNext, periodRef;
  logic            primed, measStrobe, prevKnown;

  assign mRise = pinRise[MCLK_IX];
  assign wRise = pinRise[WCLK_IX];

  always_comb begin
    mclkNext = (&mclkRun) ? mclkRun : mclkRun + MC_W'(mRise);
    refNext  = (&refRun)  ? refRun  : refRun + 1'b1;
  end

  // period counters, closed on each word-clock rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclkRun    <= '0;
      refRun     <= '0;
      periodMclk <= '0;
      periodRef  <= '0;
      primed     <= 1'b0;
      measStrobe <= 1'b0;
    end else if (wRise) begin
      periodMclk <= mclkNext;
      periodRef  <= refNext;
      mclkRun    <= '0;
      refRun     <= '0;
      primed     <= 1'b1;
      measStrobe <= primed;
    end else begin
      mclkRun    <= mclkNext;
      refRun     <= refNext;
      measStrobe <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevMclk  <= '0;
      prevKnown <= 1'b0;
    end else if (measStrobe) begin
      prevMclk  <= periodMclk;
      prevKnown <= 1'b1;
    end
  end

  // ratio classification
  logic [NUM_RATIOS-1:0] ratioHit;
  for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_ratio
    localparam logic [MC_W-1:0] NOM_LO = MC_W'(ratioNominal(k) - TOL);
    localparam logic [MC_W-1:0] NOM_HI = MC_W'(ratioNominal(k) + TOL);
    assign ratioHit[k] = (periodMclk >= NOM_LO) && (periodMclk <= NOM_HI);
  end

  ratio_code_e candCode;
  speed_mode_e candMode;

  always_comb begin
    candCode = RC_NONE;
    for (int k = NUM_RATIOS - 1; k >= 0; k--) begin
      if (ratioHit[k]) candCode = ratio_code_e'(3'(k));
    end
  end

  always_comb begin
    if (periodRef >= QUAD_MIN && periodRef <= QUAD_MAX)
      candMode = SM_QUAD;
    else if (periodRef >= DOUBLE_MIN && periodRef <= DOUBLE_MAX)
      candMode = SM_DOUBLE;
    else if (periodRef >= SINGLE_MIN && periodRef <= SINGLE_MAX)
      candMode = SM_SINGLE;
    else
      candMode = SM_NONE;
  end

  assign gap = (periodMclk >= prevMclk) ? (periodMclk - prevMclk) : (prevMclk - periodMclk);

  always_comb begin
    measStat.strobe       = measStrobe;
    measStat.good         = (candCode != RC_NONE) && (candMode != SM_NONE) &&
                            modeAllows(candMode, candCode);
    measStat.nearPrev     = prevKnown && (gap <= TOL_V);
    measStat.sameAsLocked = (candCode == lockedCode) && (candMode == lockedMode);
    measStat.allAlive     = &pinAlive;
  end

  // locked result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockedCode <= RC_NONE;
      lockedMode <= SM_NONE;
    end else if (lockCmd.lockClear) begin
      lockedCode <= RC_NONE;
      lockedMode <= SM_NONE;
    end else if (lockCmd.lockLoad) begin
      lockedCode <= candCode;
      lockedMode <= candMode;
    end
  end

endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
  import rate_mode_pkg::*;
#(
  parameter int LOCK_PERIODS   = 4,
  parameter int CHANGE_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  meas_stat_t measStat,
  output lock_cmd_t  lockCmd,
  output logic       rateValid,
  output logic       ratioChange
);

  localparam int RUN_W  = $clog2(LOCK_PERIODS + 1);
  localparam int MISS_W = $clog2(CHANGE_PERIODS + 1);
  localparam logic [RUN_W-1:0]  LOCK_V   = RUN_W'(LOCK_PERIODS);
  localparam logic [MISS_W-1:0] CHANGE_V = MISS_W'(CHANGE_PERIODS);

  typedef enum logic {ST_ACQ, ST_LOCK} lock_state_e;

  lock_state_e      state;
  logic [RUN_W-1:0] runCnt, runNext;
  logic [MISS_W-1:0] missCnt, missNext;
  logic             deviates, acqDone, dropLock;

  always_comb begin
    runNext  = (measStat.nearPrev && runCnt != '0) ? runCnt + 1'b1 : RUN_W'(1);
    missNext = missCnt + 1'b1;
    deviates = !(measStat.good && measStat.sameAsLocked);
    acqDone  = measStat.allAlive && measStat.strobe && state == ST_ACQ &&
               measStat.good && runNext >= LOCK_V;
    dropLock = measStat.allAlive && measStat.strobe && state == ST_LOCK &&
               deviates && missNext >= CHANGE_V;
    lockCmd.lockLoad  = acqDone;
    lockCmd.lockClear = !measStat.allAlive || dropLock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_ACQ;
      runCnt      <= '0;
      missCnt     <= '0;
      rateValid   <= 1'b0;
      ratioChange <= 1'b0;
    end else begin
      ratioChange <= 1'b0;
      if (!measStat.allAlive) begin
        state     <= ST_ACQ;
        runCnt    <= '0;
        missCnt   <= '0;
        rateValid <= 1'b0;
      end else if (measStat.strobe) begin
        case (state)
          ST_ACQ: begin
            if (!measStat.good) begin
              runCnt <= '0;
            end else if (acqDone) begin
              state     <= ST_LOCK;
              runCnt    <= '0;
              missCnt   <= '0;
              rateValid <= 1'b1;
            end else begin
              runCnt <= runNext;
            end
          end
          ST_LOCK: begin
            if (!deviates) begin
              missCnt <= '0;
            end else if (dropLock) begin
              state       <= ST_ACQ;
              missCnt     <= '0;
              runCnt      <= measStat.good ? RUN_W'(1) : '0;
              rateValid   <= 1'b0;
              ratioChange <= 1'b1;
            end else begin
              missCnt <= missNext;
            end
          end
          default: state <= ST_ACQ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rate_mode_detect.sv
module rate_mode_detect
  import rate_mode_pkg::*;
#(
  parameter int REF_HZ         = 200_000_000,
  parameter int TIMEOUT_DIV    = 4000,
  parameter int TOL            = 2,
  parameter int MAX_RATIO      = 1024,
  parameter int LOCK_PERIODS   = 4,
  parameter int CHANGE_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclkIn,
  input  logic       bclkIn,
  input  logic       wclkIn,
  output logic [2:0] ratioCode,
  output logic [1:0] speedMode,
  output logic       rateValid,
  output logic       ratioChange
);

  lock_cmd_t   lockCmd;
  meas_stat_t  measStat;
  ratio_code_e lockedCode;
  speed_mode_e lockedMode;
  logic [NUM_PINS-1:0] pinsIn;
  logic statAlive, statStrobe;

  assign pinsIn     = {wclkIn, bclkIn, mclkIn};
  assign statAlive  = measStat.allAlive;
  assign statStrobe = measStat.strobe;

  rate_meas_path #(
    .REF_HZ(REF_HZ), .TIMEOUT_DIV(TIMEOUT_DIV), .TOL(TOL), .MAX_RATIO(MAX_RATIO)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .pinsIn(pinsIn), .lockCmd(lockCmd),
    .measStat(measStat), .lockedCode(lockedCode), .lockedMode(lockedMode)
  );

  rate_lock_ctrl #(
    .LOCK_PERIODS(LOCK_PERIODS), .CHANGE_PERIODS(CHANGE_PERIODS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .measStat(measStat), .lockCmd(lockCmd),
    .rateValid(rateValid), .ratioChange(ratioChange)
  );

  assign ratioCode = lockedCode;
  assign speedMode = lockedMode;

endmodule

// File: rtl/rate_mode_detect_chk.sv
module rate_mode_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ratioCode,
  input logic [1:0] speedMode,
  input logic       rateValid,
  input logic       ratioChange,
  input logic       statAlive,
  input logic       statStrobe
);

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !rateValid |-> (ratioCode == 3'd7 && speedMode == 2'd0));

  a_r10_valid_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    rateValid |-> (ratioCode != 3'd7 && speedMode != 2'd0));

  a_r4_quad_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rateValid && speedMode == 2'd3) |-> ratioCode <= 3'd2);

  a_r4_double_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rateValid && speedMode == 2'd2) |-> ratioCode <= 3'd4);

  a_r4_single_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rateValid && speedMode == 2'd1) |-> (ratioCode >= 3'd2 && ratioCode <= 3'd6));

  a_r5_rise_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rateValid) |-> $past(statStrobe));

  a_r7_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ratioChange |-> !rateValid);

  a_r7_change_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ratioChange |=> !ratioChange);

  a_r9_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !statAlive |=> (!rateValid && !ratioChange));

  a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rateValid && $past(rateValid)) |-> ($stable(ratioCode) && $stable(speedMode)));

endmodule

bind rate_mode_detect rate_mode_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ratioCode(ratioCode), .speedMode(speedMode),
  .rateValid(rateValid), .ratioChange(ratioChange),
  .statAlive(statAlive), .statStrobe(statStrobe)
);

// File: tb/rate_mode_detect_tb.sv
module rate_mode_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 49_152_000;
  localparam int WATCHDOG   = 190_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclkIn = 1'b0, bclkIn = 1'b0, wclkIn = 1'b0;
  logic [2:0] ratioCode;
  logic [1:0] speedMode;
  logic rateValid, ratioChange;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rate_mode_detect #(.REF_HZ(REF_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .mclkIn(mclkIn), .bclkIn(bclkIn), .wclkIn(wclkIn),
    .ratioCode(ratioCode), .speedMode(speedMode),
    .rateValid(rateValid), .ratioChange(ratioChange)
  );

  always @(negedge clk) if (rst_n && ratioChange) pulses++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n  = 1'b0;
    mclkIn = 1'b0; bclkIn = 1'b0; wclkIn = 1'b0;
    repeat (5) @(negedge clk);
    rst_n  = 1'b1;
    pulses = 0;
    repeat (2) @(negedge clk);
  endtask

  // one word-clock frame: per = master period in ref cycles, ratio = master edges
  task automatic runFrame(int per, int ratio, bit mOn, bit bOn);
    int len = per * ratio;
    int bper = len / 64;
    for (int ph = 0; ph < len; ph++) begin
      @(negedge clk);
      mclkIn = mOn && ((ph % per) < per / 2);
      bclkIn = bOn && ((ph % bper) < bper / 2);
      wclkIn = ph < len / 2;
    end
  endtask

  task automatic runFrames(int n, int per, int ratio, bit mOn, bit bOn);
    for (int i = 0; i < n; i++) runFrame(per, ratio, mOn, bOn);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 valid", rateValid, 0);
    chk("R1 code", ratioCode, 7);
    chk("R1 mode", speedMode, 0);
    chk("R1 change", ratioChange, 0);
  endtask

  // R2 R3 R5: lock to a supported ratio and rate
  task automatic testLock(int per, int ratio, int expCode, int expMode);
    doReset();
    runFrames(4, per, ratio, 1'b1, 1'b1);
    chk("R5 not before fifth edge", rateValid, 0);
    runFrames(1, per, ratio, 1'b1, 1'b1);
    chk("R5 valid", rateValid, 1);
    chk("R2 ratio code", ratioCode, expCode);
    chk("R3 speed mode", speedMode, expMode);
  endtask

  task automatic testNoLock(string req, int per, int ratio);
    doReset();
    runFrames(8, per, ratio, 1'b1, 1'b1);
    chk(req, rateValid, 0);
    chk({req, " code"}, ratioCode, 7);
  endtask

  // R5 R6: alternating counts inside and outside the +-2 window
  task automatic testTolerance();
    doReset();
    for (int i = 0; i < 3; i++) begin
      runFrame(2, 511, 1'b1, 1'b1);
      runFrame(2, 513, 1'b1, 1'b1);
    end
    chk("R5 lock with +-2 spread", rateValid, 1);
    chk("R5 code with spread", ratioCode, 4);
    doReset();
    for (int i = 0; i < 4; i++) begin
      runFrame(2, 510, 1'b1, 1'b1);
      runFrame(2, 514, 1'b1, 1'b1);
    end
    chk("R6 spread of 4 blocks lock", rateValid, 0);
  endtask

  // R7 R10: one deviating period is ignored
  task automatic testSingleDeviation();
    doReset();
    runFrames(5, 2, 512, 1'b1, 1'b1);
    runFrame(2, 256, 1'b1, 1'b1);
    runFrames(3, 2, 512, 1'b1, 1'b1);
    chk("R7 no pulse on one period", pulses, 0);
    chk("R7 still valid", rateValid, 1);
    chk("R10 code held", ratioCode, 4);
    chk("R10 mode held", speedMode, 1);
  endtask

  // R7 R8: two deviating periods give one pulse, then relock
  task automatic testChange();
    doReset();
    runFrames(5, 2, 512, 1'b1, 1'b1);
    runFrames(1, 4, 256, 1'b1, 1'b1);
    chk("R7 one new period no pulse", pulses, 0);
    chk("R7 one new period still valid", rateValid, 1);
    runFrames(2, 4, 256, 1'b1, 1'b1);
    chk("R7 one pulse after two periods", pulses, 1);
    chk("R7 valid cleared", rateValid, 0);
    runFrames(3, 4, 256, 1'b1, 1'b1);
    chk("R8 relocked", rateValid, 1);
    chk("R8 new code", ratioCode, 2);
    chk("R8 mode", speedMode, 1);
    chk("R8 single pulse", pulses, 1);
  endtask

  // R9: bit clock stops while locked, then returns; also absent from start
  task automatic testLoss();
    doReset();
    runFrames(5, 2, 512, 1'b1, 1'b1);
    runFrames(11, 2, 512, 1'b1, 1'b0);
    chk("R9 valid before timeout", rateValid, 1);
    runFrames(2, 2, 512, 1'b1, 1'b0);
    chk("R9 valid cleared after timeout", rateValid, 0);
    chk("R9 code cleared", ratioCode, 7);
    chk("R9 no pulse on loss", pulses, 0);
    runFrames(5, 2, 512, 1'b1, 1'b1);
    chk("R9 relock after return", rateValid, 1);
    doReset();
    runFrames(6, 2, 512, 1'b1, 1'b0);
    chk("R9 no lock without bit clock", rateValid, 0);
  endtask

  initial begin
    testReset();
    testLock(2, 512, 4, 1);   // 48 kHz single
    testLock(2, 128, 0, 3);   // 192 kHz quad
    testLock(2, 256, 2, 2);   // 96 kHz double
    testLock(2, 1024, 6, 1);  // 24 kHz single
    testLock(2, 768, 5, 1);   // 32 kHz single
    testNoLock("R3 64 kHz unsupported", 2, 384);
    testNoLock("R4 ratio 128 in single", 8, 128);
    testNoLock("R2 ratio 64 not a code", 4, 64);
    testTolerance();
    testSingleDeviation();
    testChange();
    testLoss();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule